// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block derives every digital drive clock of a three-row linear CCD from one fast reference clock. All clocks are slow compared with that reference, so each is built from a free-running pixel phase counter. Inside one pixel period, the reset-gate pulse (`rb`) and the reset-level clamp pulse (`clb`) are decoded from fixed phase windows. The complementary shift-register clocks (`phi1`, `phi2`) split the period in two halves. A one-cycle converter strobe (`adc_strobe`) is placed after the clamp window. Every width and position is a parameter counted in reference cycles. With a 100 MHz reference the defaults give a 1 MHz pixel rate, a 40 ns reset pulse, a 50 ns clamp pulse, 950 ns of shift-clock margin on each side of the transfer pulse, and a 5 us transfer pulse.

Each line starts with a transfer phase. `phi1` is forced high, the transfer-gate pulse `tg` is raised and then dropped, and `phi1` is held high a little longer. `rb` and `clb` keep running through this phase. The readout phase follows. It steps through the line's pixel periods in a fixed order: optical-black periods, leading dummy periods, active periods and trailing dummy periods. It publishes the pixel index, a line-start flag and an active-pixel flag. While `run_req` is high, lines repeat. The distance from one transfer pulse to the next is the integration time given on `integ_cycles`. It is never shorter than a full readout, and the transfer phase is launched at a pixel phase chosen so that readout begins exactly on a pixel boundary.

Top module: `ccd_clock_gen`

## Requirements
- R1: While `rst_n` is low, `tg`, `line_start`, `pix_valid` and `adc_strobe` are 0 and `pix_idx` is 0.
- R2: `rb` goes high once every `P_CYC` cycles, for `RB_LEN` cycles. `clb` rises `CLB_POS-RB_POS` cycles after each `rb` rise and stays high for `CLB_LEN` cycles. This holds in every state, including the transfer phase.
- R3: `phi2` is always the inverse of `phi1`. During readout, `phi1` is low for the first `P_CYC/2` cycles of each pixel period (phases 0 to `P_CYC/2-1`, where phase `RB_POS` is the first cycle of `rb`) and high for the rest.
- R4: `phi1` is high continuously for exactly `SETUP_CYC` cycles before the cycle in which `tg` rises. It stays high for exactly `HOLD_CYC` cycles after `tg` falls, and then falls in the first readout cycle.
- R5: Every `tg` pulse is high for exactly `TG_CYC` cycles.
- R6: Readout begins with a one-cycle `line_start` while `pix_idx` is 0. `pix_idx` then counts 0, 1, … up to `N_OB+N_LEAD+N_VALID+N_TRAIL-1`, holding each value for `P_CYC` cycles, and returns to 0 after the last pixel.
- R7: The pixel order in a line is optical black (indices 0 to `N_OB-1`), then leading dummy, then active, then trailing dummy. `pix_valid` is 1 exactly for indices `N_OB+N_LEAD` to `N_OB+N_LEAD+N_VALID-1` during readout, and 0 at all other times.
- R8: `adc_strobe` is high for one cycle at phase `SAMP_POS` (after the clamp window and with `phi1` high), only while `pix_valid` is 1. There are exactly `N_VALID` strobes per line.
- R9: The interval between consecutive `tg` rises is `P_CYC*ceil(max(I, L)/P_CYC)`. Here `I` is the `integ_cycles` value sampled when the earlier line's transfer phase starts, and `L` = `SETUP_CYC+TG_CYC+HOLD_CYC+P_CYC*(N_OB+N_LEAD+N_VALID+N_TRAIL)`.
- R10: `tg` never rises during readout. When `run_req` is low at the end of a line, no further `tg` pulse is issued, and a line already in progress still completes. After `run_req` rises from idle, `tg` rises within `P_CYC+SETUP_CYC+1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req | input | 1 | Lines are repeated while high |
| integ_cycles | input | INTEG_W | Requested line period in reference cycles |
| tg | output | 1 | Transfer-gate pulse |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| rb | output | 1 | Reset-gate pulse |
| clb | output | 1 | Reset-level clamp pulse |
| pix_idx | output | PIX_W | Pixel index within the line during readout |
| line_start | output | 1 | First cycle of readout |
| pix_valid | output | 1 | Current pixel is an active pixel |
| adc_strobe | output | 1 | One-cycle converter sample strobe |

## Verification
The embedded assertions check these relations on every cycle:
- `phi1` stays high whenever `tg` is high.
- `tg` and readout never overlap.
- The strobe appears only on an active pixel, outside the `rb` and `clb` windows.
- `line_start` coincides with the falling edge of `phi1`.
- The pixel index only steps up by one or wraps to zero.
- Every transfer pulse has the exact width.

Other properties can only be shown by the bench's line-level scenarios. These are the exact setup and hold counts around the transfer pulse, the region boundaries of `pix_valid`, the strobe count per line, the rounded line period under small, exact-boundary and large integration requests, and the stop and restart behaviour of `run_req`.

// File: rtl/ccdtg_pkg.sv
// Shared types for the CCD drive clock sequencer.
package ccdtg_pkg;

    // Line sequencer states, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_TGHI  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_READ  = 3'd4
    } ccdtg_state_e;

endpackage

// File: rtl/ccdtg_phase.sv
// Pixel phase counter and per-pixel pulse decoder.
// Counts 0..P_CYC-1 without pause from reset, and decodes from the phase
// the reset-gate window, the clamp window, the split point of the shift
// clocks and the converter sample point.
// Assumes: RB_POS+RB_LEN <= CLB_POS, CLB_POS+CLB_LEN <= SAMP_POS < P_CYC.
module ccdtg_phase #(
    parameter int P_CYC    = 100,
    parameter int RB_POS   = 2,
    parameter int RB_LEN   = 4,
    parameter int CLB_POS  = 8,
    parameter int CLB_LEN  = 5,
    parameter int SAMP_POS = 60,
    parameter int PH_W     = $clog2(P_CYC)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_o,
    output logic            ph_last_o,
    output logic            ph_first_o,
    output logic            rb_o,
    output logic            clb_o,
    output logic            phi_base_o,
    output logic            samp_pt_o
);

    localparam logic [PH_W:0]   RB_LO  = (PH_W+1)'(RB_POS);
    localparam logic [PH_W:0]   RB_HI  = (PH_W+1)'(RB_POS + RB_LEN);
    localparam logic [PH_W:0]   CLB_LO = (PH_W+1)'(CLB_POS);
    localparam logic [PH_W:0]   CLB_HI = (PH_W+1)'(CLB_POS + CLB_LEN);
    localparam logic [PH_W-1:0] HALF   = PH_W'(P_CYC / 2);
    localparam logic [PH_W-1:0] LAST   = PH_W'(P_CYC - 1);
    localparam logic [PH_W-1:0] SAMP   = PH_W'(SAMP_POS);

    logic [PH_W-1:0] ph_q;
    logic [PH_W:0]   ph_x;

    // Free-running phase counter, wraps at the end of each pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_q == LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Window decode of the per-pixel pulses from the phase.
    always_comb begin
        ph_x       = {1'b0, ph_q};
        rb_o       = (ph_x >= RB_LO) && (ph_x < RB_HI);
        clb_o      = (ph_x >= CLB_LO) && (ph_x < CLB_HI);
        phi_base_o = (ph_q >= HALF);
        samp_pt_o  = (ph_q == SAMP);
        ph_last_o  = (ph_q == LAST);
        ph_first_o = (ph_q == '0);
        ph_o       = ph_q;
    end

endmodule

// File: rtl/ccdtg_pixcnt.sv
// Pixel index counter and line region decoder.
// Steps the index at each pixel-period wrap while readout runs and
// flags the active region; the order is optical black, leading dummy,
// active, trailing dummy.
// Assumes: read_i rises on a pixel boundary (phase 0).
module ccdtg_pixcnt #(
    parameter int N_OB    = 49,
    parameter int N_LEAD  = 2,
    parameter int N_VALID = 10600,
    parameter int N_TRAIL = 3,
    parameter int NPIX    = N_OB + N_LEAD + N_VALID + N_TRAIL,
    parameter int PIX_W   = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read_i,
    input  logic             ph_last_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             pix_last_o,
    output logic             valid_o
);

    localparam logic [PIX_W-1:0] LAST_IDX = PIX_W'(NPIX - 1);
    localparam logic [PIX_W:0]   V_LO     = (PIX_W+1)'(N_OB + N_LEAD);
    localparam logic [PIX_W:0]   V_HI     = (PIX_W+1)'(N_OB + N_LEAD + N_VALID);

    logic [PIX_W-1:0] pix_q;
    logic [PIX_W:0]   pix_x;

    // Index advances once per pixel period during readout, else parks at 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !read_i) begin
            pix_q <= '0;
        end else if (ph_last_i) begin
            pix_q <= (pix_q == LAST_IDX) ? '0 : pix_q + 1'b1;
        end
    end

    // Region decode of the current index.
    always_comb begin
        pix_x      = {1'b0, pix_q};
        valid_o    = read_i && (pix_x >= V_LO) && (pix_x < V_HI);
        pix_last_o = (pix_q == LAST_IDX);
        pix_o      = pix_q;
    end

    // R6: the index only steps forward by one or wraps to zero.
    assert_pix_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_q != $past(pix_q)) |-> ((pix_q == $past(pix_q) + 1'b1) || (pix_q == '0)));

endmodule

// File: rtl/ccdtg_seq.sv
// Line sequencer: transfer phase (setup, pulse, hold) then readout.
// Launches a line only at the phase that makes readout start on a pixel
// boundary, only once the requested integration time has elapsed since
// the previous launch, and only while run_req is high.
// Assumes: SETUP_CYC, TG_CYC, HOLD_CYC >= 1; integ_cycles sampled at launch.
module ccdtg_seq
    import ccdtg_pkg::*;
#(
    parameter int P_CYC     = 100,
    parameter int PH_W      = $clog2(P_CYC),
    parameter int SETUP_CYC = 95,
    parameter int TG_CYC    = 500,
    parameter int HOLD_CYC  = 95,
    parameter int INTEG_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_req,
    input  logic [INTEG_W-1:0] integ_cycles,
    input  logic [PH_W-1:0]    ph_i,
    input  logic               ph_last_i,
    input  logic               pix_last_i,
    output logic               tg_o,
    output logic               hold_hi_o,
    output logic               read_o
);

    localparam int SEQ_LEN   = SETUP_CYC + TG_CYC + HOLD_CYC;
    localparam int START_PH  = (P_CYC - (SEQ_LEN % P_CYC)) % P_CYC;
    localparam int LAUNCH_PH = (START_PH + P_CYC - 1) % P_CYC;
    localparam int SEG_MAX   = (TG_CYC > SETUP_CYC) ?
                               ((TG_CYC > HOLD_CYC) ? TG_CYC : HOLD_CYC) :
                               ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
    localparam int SEG_W     = $clog2(SEG_MAX + 1);
    localparam logic [PH_W-1:0]  LAUNCH_V = PH_W'(LAUNCH_PH);
    localparam logic [SEG_W-1:0] SETUP_E  = SEG_W'(SETUP_CYC - 1);
    localparam logic [SEG_W-1:0] TG_E     = SEG_W'(TG_CYC - 1);
    localparam logic [SEG_W-1:0] HOLD_E   = SEG_W'(HOLD_CYC - 1);

    ccdtg_state_e       st_q, st_d;
    logic [SEG_W-1:0]   seg_q;
    logic [INTEG_W-1:0] line_cnt_q;
    logic [INTEG_W-1:0] integ_q;
    logic [INTEG_W:0]   cnt_p1;
    logic               elapsed;
    logic               go;
    logic               launch;
    logic [SEG_W-1:0]   chk_tg_len;

    // Launch condition: enabled, integration time spent, right phase.
    always_comb begin
        cnt_p1  = {1'b0, line_cnt_q} + (INTEG_W+1)'(1);
        elapsed = (cnt_p1 >= {1'b0, integ_q});
        go      = run_req && elapsed && (ph_i == LAUNCH_V);
    end

    // Next-state decision for the line sequencer.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = ST_SETUP;
            ST_SETUP: if (seg_q == SETUP_E) st_d = ST_TGHI;
            ST_TGHI:  if (seg_q == TG_E) st_d = ST_HOLD;
            ST_HOLD:  if (seg_q == HOLD_E) st_d = ST_READ;
            ST_READ:  if (pix_last_i && ph_last_i) st_d = go ? ST_SETUP : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        launch = (st_d == ST_SETUP) && (st_q != ST_SETUP);
    end

    // State and segment counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            seg_q <= '0;
        end else begin
            st_q  <= st_d;
            seg_q <= (st_d != st_q) ? '0 : seg_q + 1'b1;
        end
    end

    // Integration timer: restarts at each launch and saturates when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '1;
            integ_q    <= '0;
        end else if (launch) begin
            line_cnt_q <= '0;
            integ_q    <= integ_cycles;
        end else if (line_cnt_q != '1) begin
            line_cnt_q <= line_cnt_q + 1'b1;
        end
    end

    // Decoded controls for the clock outputs.
    always_comb begin
        tg_o      = (st_q == ST_TGHI);
        hold_hi_o = (st_q == ST_SETUP) || (st_q == ST_TGHI) || (st_q == ST_HOLD);
        read_o    = (st_q == ST_READ);
    end

    // Checker counter: length of the current transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !tg_o) begin
            chk_tg_len <= '0;
        end else begin
            chk_tg_len <= chk_tg_len + 1'b1;
        end
    end

    // R5: each transfer pulse lasts exactly TG_CYC cycles.
    assert_tg_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tg_o) |-> (chk_tg_len == SEG_W'(TG_CYC)));

endmodule

// File: rtl/ccd_clock_gen.sv
// Top of the CCD drive clock sequencer.
// Combines the pixel phase decoder, the line sequencer and the pixel
// counter into the drive clocks, the pixel index and the converter strobe.
// Assumes: clk is the timing reference; all widths are in its cycles.
module ccd_clock_gen
    import ccdtg_pkg::*;
#(
    parameter int P_CYC     = 100,
    parameter int RB_POS    = 2,
    parameter int RB_LEN    = 4,
    parameter int CLB_POS   = 8,
    parameter int CLB_LEN   = 5,
    parameter int SAMP_POS  = 60,
    parameter int SETUP_CYC = 95,
    parameter int TG_CYC    = 500,
    parameter int HOLD_CYC  = 95,
    parameter int N_OB      = 49,
    parameter int N_LEAD    = 2,
    parameter int N_VALID   = 10600,
    parameter int N_TRAIL   = 3,
    parameter int INTEG_W   = 24,
    parameter int NPIX      = N_OB + N_LEAD + N_VALID + N_TRAIL,
    parameter int PIX_W     = $clog2(NPIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_req,
    input  logic [INTEG_W-1:0] integ_cycles,
    output logic               tg,
    output logic               phi1,
    output logic               phi2,
    output logic               rb,
    output logic               clb,
    output logic [PIX_W-1:0]   pix_idx,
    output logic               line_start,
    output logic               pix_valid,
    output logic               adc_strobe
);

    localparam int PH_W = $clog2(P_CYC);

    logic [PH_W-1:0] ph;
    logic            ph_last, ph_first, phi_base, samp_pt;
    logic            hold_hi, reading, pix_last;

    ccdtg_phase #(
        .P_CYC(P_CYC), .RB_POS(RB_POS), .RB_LEN(RB_LEN),
        .CLB_POS(CLB_POS), .CLB_LEN(CLB_LEN), .SAMP_POS(SAMP_POS), .PH_W(PH_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .ph_o(ph), .ph_last_o(ph_last),
        .ph_first_o(ph_first), .rb_o(rb), .clb_o(clb),
        .phi_base_o(phi_base), .samp_pt_o(samp_pt)
    );

    ccdtg_seq #(
        .P_CYC(P_CYC), .PH_W(PH_W), .SETUP_CYC(SETUP_CYC),
        .TG_CYC(TG_CYC), .HOLD_CYC(HOLD_CYC), .INTEG_W(INTEG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .integ_cycles(integ_cycles),
        .ph_i(ph), .ph_last_i(ph_last), .pix_last_i(pix_last),
        .tg_o(tg), .hold_hi_o(hold_hi), .read_o(reading)
    );

    ccdtg_pixcnt #(
        .N_OB(N_OB), .N_LEAD(N_LEAD), .N_VALID(N_VALID), .N_TRAIL(N_TRAIL),
        .NPIX(NPIX), .PIX_W(PIX_W)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .read_i(reading), .ph_last_i(ph_last),
        .pix_o(pix_idx), .pix_last_o(pix_last), .valid_o(pix_valid)
    );

    // Output shaping: phi1 forced high over the transfer phase.
    always_comb begin
        phi1       = hold_hi ? 1'b1 : phi_base;
        phi2       = ~phi1;
        line_start = reading && ph_first && (pix_idx == '0);
        adc_strobe = pix_valid && samp_pt;
    end

    // R4: the shift clock phase 1 is high throughout the transfer pulse.
    assert_phi1_over_tg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tg |-> phi1);

    // R10: transfer pulse and readout never overlap.
    assert_tg_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tg |-> (!pix_valid && !line_start && (pix_idx == '0)));

    // R8: a strobe only lands on an active pixel, clear of rb and clb.
    assert_strobe_place_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> (pix_valid && !rb && !clb && phi1));

    // R6: readout starts exactly when phi1 drops after the hold.
    assert_line_start_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> $fell(phi1));

endmodule

// File: tb/tb_ccd_clock_gen.sv
// Bench for the CCD drive clock sequencer: reduced pixel counts, real
// pulse timing at a 100 MHz reference; line periods from random and
// directed integration requests.
module tb_ccd_clock_gen;

    localparam int P_CYC = 100, RB_POS = 2, RB_LEN = 4, CLB_POS = 8, CLB_LEN = 5;
    localparam int SAMP_POS = 60, SETUP_CYC = 95, TG_CYC = 500, HOLD_CYC = 95;
    localparam int N_OB = 4, N_LEAD = 2, N_VALID = 10, N_TRAIL = 3;
    localparam int NPIX = N_OB + N_LEAD + N_VALID + N_TRAIL;
    localparam int PIX_W = $clog2(NPIX);
    localparam int INTEG_W = 16;
    localparam int MIN_LINE = SETUP_CYC + TG_CYC + HOLD_CYC + P_CYC * NPIX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0;
    logic [INTEG_W-1:0] integ_cycles = '0;
    logic tg, phi1, phi2, rb, clb, line_start, pix_valid, adc_strobe;
    logic [PIX_W-1:0] pix_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    bit mon_en = 0;

    ccd_clock_gen #(
        .P_CYC(P_CYC), .RB_POS(RB_POS), .RB_LEN(RB_LEN), .CLB_POS(CLB_POS),
        .CLB_LEN(CLB_LEN), .SAMP_POS(SAMP_POS), .SETUP_CYC(SETUP_CYC),
        .TG_CYC(TG_CYC), .HOLD_CYC(HOLD_CYC), .N_OB(N_OB), .N_LEAD(N_LEAD),
        .N_VALID(N_VALID), .N_TRAIL(N_TRAIL), .INTEG_W(INTEG_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .integ_cycles(integ_cycles),
        .tg(tg), .phi1(phi1), .phi2(phi2), .rb(rb), .clb(clb),
        .pix_idx(pix_idx), .line_start(line_start), .pix_valid(pix_valid),
        .adc_strobe(adc_strobe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_period(input int integ);
        int m;
        m = (integ > MIN_LINE) ? integ : MIN_LINE;
        return ((m + P_CYC - 1) / P_CYC) * P_CYC;
    endfunction

    // Monitor state
    bit rb_p, clb_p, tg_p, phi1_p, ph_known, reading, in_hold, have_prev, first_rise;
    int phm, rb_len, clb_len, rb_last, phi1_run, tg_len, hold_cnt;
    int idx_exp, idx_dur, strobes, last_rise, integ_at, tg_rises, raise_cyc;

    always @(negedge clk) begin
        if (mon_en) begin
            if (ph_known) phm = (phm + 1) % P_CYC;
            // R3: complementary shift clocks
            chk(phi2 == !phi1, "R3 phi2 inverse", phi2, !phi1);
            // R2: reset gate period and width, clamp offset and width
            if (rb && !rb_p) begin
                if (ph_known) chk(cyc - rb_last == P_CYC, "R2 rb period", cyc - rb_last, P_CYC);
                ph_known = 1; phm = RB_POS; rb_last = cyc; rb_len = 0;
            end
            if (rb) rb_len++;
            if (!rb && rb_p) chk(rb_len == RB_LEN, "R2 rb width", rb_len, RB_LEN);
            if (clb && !clb_p) begin
                if (ph_known) chk(phm == CLB_POS, "R2 clb offset", phm, CLB_POS);
                clb_len = 0;
            end
            if (clb) clb_len++;
            if (!clb && clb_p) chk(clb_len == CLB_LEN, "R2 clb width", clb_len, CLB_LEN);
            // R4/R9/R10: transfer pulse rise
            if (tg && !tg_p) begin
                tg_rises++;
                chk(phi1_run == SETUP_CYC, "R4 phi1 setup", phi1_run, SETUP_CYC);
                chk(!reading, "R10 tg during readout", reading, 0);
                if (have_prev)
                    chk(cyc - last_rise == exp_period(integ_at), "R9 line period",
                        cyc - last_rise, exp_period(integ_at));
                if (first_rise) begin
                    chk((cyc - raise_cyc) <= P_CYC + SETUP_CYC + 1 && (cyc - raise_cyc) >= SETUP_CYC,
                        "R10 launch latency", cyc - raise_cyc, P_CYC + SETUP_CYC);
                    first_rise = 0;
                end
                have_prev = 1; last_rise = cyc; integ_at = int'(integ_cycles); tg_len = 0;
            end
            if (tg) tg_len++;
            if (in_hold) hold_cnt++;
            if (!tg && tg_p) begin
                chk(tg_len == TG_CYC, "R5 tg width", tg_len, TG_CYC);
                in_hold = 1; hold_cnt = 0;
            end
            if (in_hold && !phi1 && phi1_p) begin
                chk(hold_cnt == HOLD_CYC, "R4 phi1 hold", hold_cnt, HOLD_CYC);
                in_hold = 0; reading = 1; idx_exp = 0; idx_dur = 0; strobes = 0;
            end
            // R6/R7/R8: readout contents
            if (reading) begin
                bit vexp;
                vexp = (idx_exp >= N_OB + N_LEAD) && (idx_exp < N_OB + N_LEAD + N_VALID);
                chk(int'(pix_idx) == idx_exp, "R6 pixel index", pix_idx, idx_exp);
                chk(line_start == (idx_exp == 0 && idx_dur == 0), "R6 line_start",
                    line_start, (idx_exp == 0 && idx_dur == 0));
                chk(pix_valid == vexp, "R7 pix_valid region", pix_valid, vexp);
                chk(adc_strobe == (vexp && phm == SAMP_POS), "R8 strobe place",
                    adc_strobe, (vexp && phm == SAMP_POS));
                chk(phi1 == (phm >= P_CYC / 2), "R3 phi1 half", phi1, (phm >= P_CYC / 2));
                if (adc_strobe) strobes++;
                idx_dur++;
                if (idx_dur == P_CYC) begin
                    idx_dur = 0; idx_exp++;
                    if (idx_exp == NPIX) begin
                        reading = 0;
                        chk(strobes == N_VALID, "R8 strobes per line", strobes, N_VALID);
                    end
                end
            end else begin
                chk(!pix_valid && !adc_strobe && !line_start, "R7 idle flags",
                    {pix_valid, adc_strobe, line_start}, 0);
            end
            if (phi1) phi1_run++; else phi1_run = 0;
            rb_p = rb; clb_p = clb; tg_p = tg; phi1_p = phi1;
        end
    end

    task automatic wait_line_start();
        do @(negedge clk); while (!line_start);
    endtask

    initial begin
        int snap;
        void'($urandom(32'd7319));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!tg && !line_start && !pix_valid && !adc_strobe && pix_idx == '0, "R1 reset outputs",
            {tg, line_start, pix_valid, adc_strobe}, 0);
        repeat (2) @(negedge clk);
        chk(tg == 1'b0 && pix_idx == '0, "R1 reset idx", pix_idx, 0);
        rst_n = 1'b1;
        rb_p = rb; clb_p = clb; tg_p = tg; phi1_p = phi1;
        mon_en = 1;
        // R10: no transfer pulse while run_req low
        repeat (300) @(negedge clk);
        chk(tg_rises == 0, "R10 idle no tg", tg_rises, 0);
        // directed integration requests, then random
        integ_cycles = 16'd0;
        raise_cyc = cyc; first_rise = 1;
        run_req = 1'b1;
        wait_line_start(); integ_cycles = 16'(MIN_LINE);
        wait_line_start(); integ_cycles = 16'(MIN_LINE + 11);
        wait_line_start(); integ_cycles = 16'd5000;
        wait_line_start(); integ_cycles = 16'(MIN_LINE - 1);
        for (int i = 0; i < 6; i++) begin
            wait_line_start();
            integ_cycles = 16'($urandom_range(0, 5000));
        end
        // R10: stop mid-line, the line completes and no new pulse follows
        wait_line_start();
        run_req = 1'b0;
        snap = tg_rises;
        repeat (15000) @(negedge clk);
        chk(tg_rises == snap, "R10 stopped no tg", tg_rises - snap, 0);
        chk(!reading, "R10 line completed", reading, 0);
        // restart
        have_prev = 0;
        integ_cycles = 16'd3000;
        raise_cyc = cyc; first_rise = 1;
        run_req = 1'b1;
        for (int i = 0; i < 3; i++) wait_line_start();
        chk(tg_rises == snap + 3, "R10 restart lines", tg_rises - snap, 3);
        repeat (3000) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule